// File: doc/BRIEF.md
# Parallel NOR Flash Command Engine

A synthesizable behavioural model of the command side of a byte-wide parallel NOR flash. It holds a small internal byte array. The array is split into sectors with a boot region of smaller sectors. Writes arrive as single-clock strobe cycles on an address/data bus. Multi-cycle unlock-and-command sequences start timed embedded program and erase operations. While such an operation runs, a read returns a status byte instead of array data, and a ready output is held low.

The engine also supports several operating modes. An unlock-bypass mode shortens programming to two write cycles. A running erase can be suspended so that other sectors can be read or programmed. A running program can be suspended so that other bytes can be read. An active-low hardware reset aborts whatever is running. Program and erase durations are parameters, and the sector sizes are scaled down from a 35-sector map. A parameter places the boot sectors at the bottom or at the top of the array.

Top module: `nor_cmd_engine`

## Requirements
- R1: The array is all 0xFF at power-up. Holding `rst_n` low aborts any program or erase, forces `ready` high, clears unlock-bypass mode and returns to array reads. Array contents that were already written are kept.
- R2: Four write cycles start a program: 0xAA at address 0x155, 0x55 at 0x0AA, 0xA0 at 0x155, then the target address and data. After PROG_CYCLES busy cycles the byte holds old AND new, so bits can only go from 1 to 0.
- R3: `ready` is low exactly while a program or erase is running and not suspended. It is high at all other times, including while an operation is suspended. It is sampled on the clock after the accepting write.
- R4: While `ready` is low, a read cycle returns a status byte. Bit 7 is the inverse of bit 7 of the data being programmed during a program, and 0 during an erase. Bit 6 is a toggle that starts at 0 after reset and flips on every read cycle. Bits 5:0 are 0. When no read cycle is active, `rdata` is 0x00.
- R5: A write that does not fit the sequence in progress returns the engine to array reads without changing the array. This includes a wrong address, a wrong data value, or 0xF0.
- R6: The sequence 0xAA@0x155, 0x55@0x0AA, 0x20@0x155 enters unlock bypass. In bypass, 0xA0 at any address followed by address/data programs a byte. The pair 0x90 then 0x00 leaves bypass. Any other write in bypass is ignored.
- R7: Sector erase is 0xAA@0x155, 0x55@0x0AA, 0x80@0x155, 0xAA@0x155, 0x55@0x0AA, then 0x30 at any address in the target sector. The erase writes 0x00 to each byte of the sector, waits ERASE_CYCLES, then writes 0xFF to each byte. It is busy for 2*size+ERASE_CYCLES cycles and leaves all other sectors unchanged.
- R8: With BIG_SEC bytes per large sector and the default bottom placement, bytes [0,BIG_SEC) form four sectors of BIG_SEC/4, BIG_SEC/8, BIG_SEC/8 and BIG_SEC/2 bytes, in that order. Above them are 31 large sectors. With TOP_BOOT=1, the 31 large sectors come first, followed by sectors of BIG_SEC/2, BIG_SEC/8, BIG_SEC/8 and BIG_SEC/4 bytes.
- R9: The erase sequence ending in 0x10 at 0x155 erases the whole array in the same way. It is busy for 2*DEPTH+ERASE_CYCLES cycles.
- R10: Writing 0xB0 during an erase suspends it. While suspended, reads inside the erasing sector return 0x80, and reads elsewhere return array data. A program outside that sector is accepted, and a program inside it is ignored. Writing 0x30 resumes the erase.
- R11: Writing 0xB0 during a program suspends it, and reads then return array data. Writing 0x30 resumes the program, which completes its remaining cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe; a write cycle needs cs_n=0, we_n=0, oe_n=1 |
| oe_n | input | 1 | Active-low output enable; a read cycle needs cs_n=0, oe_n=0, we_n=1 |
| addr | input | 9 | Byte address (log2 of 32*BIG_SEC) |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Array data or status byte during a read cycle, else 0 |
| ready | output | 1 | High when no operation is running unsuspended |

## Verification
The engine is tried with correct four-cycle and two-cycle program sequences, with a second program that tries to raise bits, and with sequences broken by a wrong address, a reset command or stray writes in bypass. Together these separate real command decoding from an engine that accepts anything. Sector erases are run on a large sector, a boot sector and a mid-size boot sector, with data planted in the neighbouring sectors. This separates a correct sector map from one that is off by a boundary. Suspend, resume, a hardware reset in mid-program and a chip erase are each exercised, and `ready` is compared with the reference on every clock, so a busy time that is off by one cycle is reported. A second instance with top boot placement is checked on its boot sector boundaries.

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int BIG_SEC = 16,
  parameter bit TOP_BOOT = 1'b0,
  parameter int PROG_CYCLES = 8,
  parameter int ERASE_CYCLES = 20,
  localparam int DEPTH = 32 * BIG_SEC,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          ready
);
  localparam int QTR = BIG_SEC / 4;
  localparam int EIG = BIG_SEC / 8;
  localparam int HALF = BIG_SEC / 2;
  localparam int PCW = $clog2(PROG_CYCLES + 1);
  localparam int ECW = $clog2(ERASE_CYCLES + 1);
  localparam logic [AW-1:0] UA = AW'(12'h555);
  localparam logic [AW-1:0] UB = AW'(12'h2AA);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_E1, S_E2, S_E3, S_PA, S_BX} seq_t;
  typedef enum logic [1:0] {P_FILL, P_WAIT, P_CLR} ph_t;

  function automatic logic [2*AW-1:0] sec_span(input logic [AW-1:0] a);
    int ai, lo, len, tb;
    ai = int'(a);
    tb = 31 * BIG_SEC;
    lo = ai - (ai % BIG_SEC);
    len = BIG_SEC;
    if (!TOP_BOOT && ai < BIG_SEC) begin
      if (ai < QTR) begin lo = 0; len = QTR; end
      else if (ai < QTR + EIG) begin lo = QTR; len = EIG; end
      else if (ai < HALF) begin lo = QTR + EIG; len = EIG; end
      else begin lo = HALF; len = HALF; end
    end else if (TOP_BOOT && ai >= tb) begin
      if (ai < tb + HALF) begin lo = tb; len = HALF; end
      else if (ai < tb + HALF + EIG) begin lo = tb + HALF; len = EIG; end
      else if (ai < tb + HALF + 2*EIG) begin lo = tb + HALF + EIG; len = EIG; end
      else begin lo = tb + HALF + 2*EIG; len = QTR; end
    end
    return {AW'(lo), AW'(lo + len - 1)};
  endfunction

  logic [7:0] mem [DEPTH];
  seq_t seq;
  ph_t er_ph;
  logic byp, tog;
  logic pg_run, pg_sus, er_run, er_sus;
  logic [AW-1:0] pg_addr, er_lo, er_hi, er_ptr;
  logic [7:0] pg_data;
  logic [PCW-1:0] pg_cnt;
  logic [ECW-1:0] er_cnt;
  logic [2*AW-1:0] span;

  wire rd = !cs_n && !oe_n && we_n;
  wire wr = !cs_n && !we_n && oe_n;
  wire pg_go = pg_run && !pg_sus;
  wire er_go = er_run && !er_sus && !pg_run;
  wire pg_done = pg_go && pg_cnt == PCW'(PROG_CYCLES - 1);
  wire er_last = er_go && er_ph == P_CLR && er_ptr == er_hi;
  wire in_er = er_run && addr >= er_lo && addr <= er_hi;
  wire mem_we = pg_done || (er_go && er_ph != P_WAIT);
  wire [AW-1:0] mem_wa = pg_done ? pg_addr : er_ptr;
  wire [7:0] mem_wd = pg_done ? (mem[pg_addr] & pg_data) : (er_ph == P_FILL ? 8'h00 : 8'hFF);

  assign span = sec_span(addr);
  assign ready = !(pg_go || (er_run && !er_sus));
  assign rdata = !rd ? 8'h00
               : pg_go ? {~pg_data[7], tog, 6'b0}
               : (er_run && !er_sus) ? {1'b0, tog, 6'b0}
               : in_er ? 8'h80
               : mem[addr];

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;

  always_ff @(posedge clk) if (mem_we) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_IDLE; er_ph <= P_FILL;
      byp <= 1'b0; tog <= 1'b0;
      pg_run <= 1'b0; pg_sus <= 1'b0; er_run <= 1'b0; er_sus <= 1'b0;
      pg_addr <= '0; pg_data <= '0; pg_cnt <= '0;
      er_lo <= '0; er_hi <= '0; er_ptr <= '0; er_cnt <= '0;
    end else begin
      if (rd) tog <= ~tog;
      if (pg_go) begin
        pg_cnt <= pg_cnt + 1'b1;
        if (pg_done) begin pg_run <= 1'b0; pg_cnt <= '0; end
      end
      if (er_go) begin
        case (er_ph)
          P_FILL: if (er_ptr == er_hi) begin er_ph <= P_WAIT; er_cnt <= '0; end
                  else er_ptr <= er_ptr + 1'b1;
          P_WAIT: if (er_cnt == ECW'(ERASE_CYCLES - 1)) begin er_ph <= P_CLR; er_ptr <= er_lo; end
                  else er_cnt <= er_cnt + 1'b1;
          default: if (er_ptr == er_hi) er_run <= 1'b0;
                   else er_ptr <= er_ptr + 1'b1;
        endcase
      end
      if (wr) begin
        if (pg_run) begin
          if (!pg_sus && wdata == 8'hB0 && !pg_done) pg_sus <= 1'b1;
          else if (pg_sus && wdata == 8'h30) pg_sus <= 1'b0;
        end else if (er_run && !er_sus) begin
          if (wdata == 8'hB0 && !er_last) er_sus <= 1'b1;
        end else begin
          seq <= S_IDLE;
          case (seq)
            S_IDLE:
              if (byp) begin
                if (wdata == 8'hA0) seq <= S_PA;
                else if (wdata == 8'h90) seq <= S_BX;
              end else if (er_sus && wdata == 8'h30) er_sus <= 1'b0;
              else if (wdata == 8'hAA && addr == UA) seq <= S_U1;
            S_U1: if (wdata == 8'h55 && addr == UB) seq <= S_U2;
            S_U2:
              if (addr == UA) begin
                if (wdata == 8'hA0) seq <= S_PA;
                else if (wdata == 8'h80 && !er_sus) seq <= S_E1;
                else if (wdata == 8'h20 && !er_sus) byp <= 1'b1;
              end
            S_E1: if (wdata == 8'hAA && addr == UA) seq <= S_E2;
            S_E2: if (wdata == 8'h55 && addr == UB) seq <= S_E3;
            S_E3:
              if ((wdata == 8'h10 && addr == UA) || wdata == 8'h30) begin
                er_run <= 1'b1; er_ph <= P_FILL; er_cnt <= '0;
                if (wdata == 8'h10) begin
                  er_lo <= '0; er_hi <= AW'(DEPTH - 1); er_ptr <= '0;
                end else begin
                  er_lo <= span[2*AW-1:AW]; er_hi <= span[AW-1:0]; er_ptr <= span[2*AW-1:AW];
                end
              end
            S_PA:
              if (!in_er) begin
                pg_run <= 1'b1; pg_sus <= 1'b0; pg_cnt <= '0;
                pg_addr <= addr; pg_data <= wdata;
              end
            S_BX: if (wdata == 8'h00) byp <= 1'b0;
            default: seq <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

module nor_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [7:0] rdata,
  input logic       ready
);
  logic seen;
  wire rd = !cs_n && !oe_n && we_n;
  wire wr = !cs_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else seen <= 1'b1;

  p_hwreset_r1: assert property (@(posedge clk) !rst_n |-> ready);
  p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n) !rd |-> rdata == 8'h00);
  p_status_low_r4: assert property (@(posedge clk) disable iff (!rst_n) (rd && !ready) |-> rdata[5:0] == 6'd0);
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rd && !ready && $past(rd && !ready)) |-> rdata[6] != $past(rdata[6]));
  p_busy_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(ready)) |-> $past(wr));
endmodule

bind nor_cmd_engine nor_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .rdata(rdata), .ready(ready)
);

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 8;
  localparam int ERASE = 20;
  localparam int DEPTH = 512;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, cs_t_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_t;
  logic ready, ready_t;

  int tests = 0, fails = 0;
  bit sel_top = 1'b0;
  bit finished = 1'b0;

  logic [7:0] rmem [DEPTH];
  int pg_left = 0, er_left = 0, pg_a = 0, er_lo = 0, er_hi = 0, nreads = 0;
  bit pg_s = 1'b0, er_s = 1'b0;
  logic [7:0] pg_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_engine #(.BIG_SEC(16), .TOP_BOOT(1'b0), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready));

  nor_cmd_engine #(.BIG_SEC(16), .TOP_BOOT(1'b1), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) dut_t (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_t_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata_t), .ready(ready_t));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_busy();
    return (pg_left > 0 && !pg_s) || (er_left > 0 && !er_s);
  endfunction

  // reference advance on each edge
  always @(posedge clk) begin
    bit pg_act, er_act;
    pg_act = pg_left > 0 && !pg_s;
    er_act = er_left > 0 && !er_s && pg_left == 0;
    if (pg_act) begin
      pg_left--;
      if (pg_left == 0) rmem[pg_a] = rmem[pg_a] & pg_d;
    end
    if (er_act) begin
      er_left--;
      if (er_left == 0) for (int i = er_lo; i <= er_hi; i++) rmem[i] = 8'hFF;
    end
  end

  // ready compared on every clock (R3)
  initial forever begin
    @(posedge clk);
    #2;
    chk("R3 ready", ready, !ref_busy());
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic void bottom_span(input int a, output int lo, output int hi);
    if (a < 4) begin lo = 0; hi = 3; end
    else if (a < 6) begin lo = 4; hi = 5; end
    else if (a < 8) begin lo = 6; hi = 7; end
    else if (a < 16) begin lo = 8; hi = 15; end
    else begin lo = a - (a % 16); hi = lo + 15; end
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    logic t;
    t = nreads[0];
    if (pg_left > 0 && !pg_s) return {~pg_d[7], t, 6'b0};
    if (er_left > 0 && !er_s) return {1'b0, t, 6'b0};
    if (er_left > 0 && a >= er_lo && a <= er_hi) return 8'h80;
    return rmem[a];
  endfunction

  task automatic bus_wr(input int a, input int d);
    addr = 9'(a); wdata = 8'(d); we_n = 1'b0;
    if (sel_top) cs_t_n = 1'b0; else cs_n = 1'b0;
    @(posedge clk); #1;
    cs_n = 1'b1; cs_t_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] v);
    addr = 9'(a); oe_n = 1'b0;
    if (sel_top) cs_t_n = 1'b0; else cs_n = 1'b0;
    #(CLK_PERIOD/2);
    v = sel_top ? rdata_t : rdata;
    @(posedge clk); #1;
    cs_n = 1'b1; cs_t_n = 1'b1; oe_n = 1'b1;
    if (!sel_top) nreads++;
  endtask

  task automatic check_rd(input string tag, input int a);
    logic [7:0] v, e;
    e = exp_read(a);
    bus_rd(a, v);
    chk(tag, v, e);
  endtask

  task automatic check_top(input string tag, input int a, input int e);
    logic [7:0] v;
    bus_rd(a, v);
    chk(tag, v, e);
  endtask

  task automatic start_prog(input int a, input int d);
    if (!sel_top && !(er_left > 0 && er_s && a >= er_lo && a <= er_hi)) begin
      pg_left = PROG; pg_s = 1'b0; pg_a = a; pg_d = 8'(d);
    end
  endtask

  task automatic prog4(input int a, input int d);
    bus_wr('h155, 'hAA); bus_wr('h0AA, 'h55); bus_wr('h155, 'hA0); bus_wr(a, d);
    start_prog(a, d);
  endtask

  task automatic byp_prog(input int a, input int d);
    bus_wr('h000, 'hA0); bus_wr(a, d);
    start_prog(a, d);
  endtask

  task automatic erase_pre();
    bus_wr('h155, 'hAA); bus_wr('h0AA, 'h55); bus_wr('h155, 'h80);
    bus_wr('h155, 'hAA); bus_wr('h0AA, 'h55);
  endtask

  task automatic sec_erase(input int a);
    int lo, hi;
    erase_pre();
    bus_wr(a, 'h30);
    if (!sel_top) begin
      bottom_span(a, lo, hi);
      er_lo = lo; er_hi = hi; er_s = 1'b0;
      er_left = 2 * (hi - lo + 1) + ERASE;
    end
  endtask

  task automatic suspend();
    bus_wr('h000, 'hB0);
    if (pg_left > 0) pg_s = 1'b1; else er_s = 1'b1;
  endtask

  task automatic resume();
    bus_wr('h000, 'h30);
    if (pg_left > 0 && pg_s) pg_s = 1'b0; else er_s = 1'b0;
  endtask

  task automatic wait_idle();
    while (ref_busy()) begin @(posedge clk); #1; end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_top();
    int n = 0;
    while (!ready_t && n < 5000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    pg_left = 0; er_left = 0; pg_s = 1'b0; er_s = 1'b0; nreads = 0;
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) rmem[i] = 8'hFF;
    idle(3);
    #1;
    rst_n = 1'b1;
    idle(1);

    // R1 / R4: reset state
    chk("R1 ready after reset", ready, 1);
    chk("R4 bus quiet", rdata, 0);
    check_rd("R1 erased at power-up", 'h40);

    // R2 / R4: four-cycle program with status polling
    prog4('h40, 'h5A);
    check_rd("R4 poll bit7 program", 'h40);
    check_rd("R4 toggle program", 'h40);
    wait_idle();
    check_rd("R2 programmed byte", 'h40);
    prog4('h40, 'hF0);
    wait_idle();
    check_rd("R2 only clears bits", 'h40);
    chk("R2 value 0x50", rmem['h40], 'h50);

    // R5: broken sequences
    bus_wr('h155, 'hAA); bus_wr('h123, 'h55); bus_wr('h155, 'hA0); bus_wr('h040, 'h00);
    check_rd("R5 wrong address ignored", 'h40);
    bus_wr('h155, 'hAA); bus_wr('h0AA, 'h55); bus_wr('h155, 'hF0); bus_wr('h040, 'h00);
    check_rd("R5 reset command mid sequence", 'h40);

    // R6: unlock bypass
    bus_wr('h155, 'hAA); bus_wr('h0AA, 'h55); bus_wr('h155, 'h20);
    byp_prog('h41, 'h33);
    wait_idle();
    check_rd("R6 bypass program", 'h41);
    bus_wr('h041, 'hF0); bus_wr('h041, 'h00);
    check_rd("R6 stray writes in bypass", 'h41);
    byp_prog('h42, 'h0F);
    wait_idle();
    check_rd("R6 second bypass program", 'h42);
    bus_wr('h000, 'h90); bus_wr('h000, 'h00);
    bus_wr('h000, 'hA0); bus_wr('h043, 'h00);
    check_rd("R6 bypass exited", 'h43);

    // R7: large sector erase
    prog4('h50, 'h12);
    wait_idle();
    sec_erase('h45);
    check_rd("R7 R4 erase status", 'h45);
    check_rd("R4 toggle erase", 'h45);
    wait_idle();
    check_rd("R7 erased low", 'h40);
    check_rd("R7 erased high", 'h4F);
    check_rd("R7 neighbour kept", 'h50);

    // R8: boot sectors, bottom placement
    prog4('h03, 'h00); wait_idle();
    prog4('h04, 'h00); wait_idle();
    prog4('h06, 'h00); wait_idle();
    prog4('h08, 'h0F); wait_idle();
    prog4('h0F, 'h0F); wait_idle();
    sec_erase('h05);
    wait_idle();
    check_rd("R8 below boot sector kept", 'h03);
    check_rd("R8 boot sector erased", 'h04);
    check_rd("R8 above boot sector kept", 'h06);
    sec_erase('h0C);
    wait_idle();
    check_rd("R8 half sector low", 'h08);
    check_rd("R8 half sector high", 'h0F);
    check_rd("R8 eighth sector kept", 'h06);

    // R10: erase suspend
    prog4('h85, 'h00); wait_idle();
    sec_erase('h80);
    idle(5);
    suspend();
    check_rd("R10 erasing sector while suspended", 'h85);
    check_rd("R10 other sector readable", 'h50);
    prog4('h90, 'h77);
    wait_idle();
    check_rd("R10 program during suspend", 'h90);
    prog4('h82, 'h00);
    idle(2);
    chk("R10 program in erasing sector rejected", ready, 1);
    resume();
    wait_idle();
    check_rd("R10 erase finished", 'h85);
    check_rd("R10 erase finished at 0x82", 'h82);
    check_rd("R10 suspended program kept", 'h90);

    // R11: program suspend
    prog4('hA0, 'h11);
    idle(2);
    suspend();
    check_rd("R11 other byte during suspend", 'hB0);
    check_rd("R11 target not yet written", 'hA0);
    idle(3);
    resume();
    wait_idle();
    check_rd("R11 program completed", 'hA0);

    // R1: hardware reset
    prog4('hC0, 'h00);
    idle(2);
    hw_reset();
    chk("R1 ready after abort", ready, 1);
    check_rd("R1 aborted program left array", 'hC0);
    bus_wr('h155, 'hAA); bus_wr('h0AA, 'h55); bus_wr('h155, 'h20);
    hw_reset();
    bus_wr('h000, 'hA0); bus_wr('h0C1, 'h00);
    check_rd("R1 bypass cleared", 'hC1);
    prog4('hC2, 'h3C);
    wait_idle();
    check_rd("R1 engine usable after reset", 'hC2);

    // R9: chip erase
    erase_pre();
    bus_wr('h155, 'h10);
    er_lo = 0; er_hi = DEPTH - 1; er_s = 1'b0; er_left = 2 * DEPTH + ERASE;
    check_rd("R9 chip erase status", 'h10);
    wait_idle();
    check_rd("R9 erased 0x50", 'h50);
    check_rd("R9 erased 0x90", 'h90);
    check_rd("R9 erased 0xC2", 'hC2);
    check_rd("R9 erased top", 'h1FF);

    // R8: top boot placement on the second instance
    sel_top = 1'b1;
    prog4('h1F7, 'h00); wait_top();
    prog4('h1F8, 'h00); wait_top();
    prog4('h1F9, 'h00); wait_top();
    prog4('h1FA, 'h00); wait_top();
    sec_erase('h1F9); wait_top();
    check_top("R8 top: large sector side kept", 'h1F7, 'h00);
    check_top("R8 top: eighth sector erased low", 'h1F8, 'hFF);
    check_top("R8 top: eighth sector erased high", 'h1F9, 'hFF);
    check_top("R8 top: next eighth sector kept", 'h1FA, 'h00);
    sel_top = 1'b0;

    idle(2);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule